// File: doc/BRIEF.md
# External Memory Bus Strobe Controller

This block sits between an 8051-style core and its off-chip memories. Program memory and external data RAM both decode the same 64 KB range starting at zero. The block keeps them apart purely through the choice of strobe. An opcode fetch, or a constant read through the 16-bit data pointer, pulses the program-store enable. An external data read pulses the read strobe, and an external data write pulses the write strobe. All three strobes are active low, and at most one is low in any cycle.

The core raises `fetch_req` with a program counter, or `move_req` with a move operation. A move takes its address in one of two ways. In full form, the 16-bit data pointer supplies all address bits. In paged form, an 8-bit register pointer supplies the low byte and a port latch supplies the high byte, so software picks the 256-byte page.

Each accepted request runs one fixed sequence of three cycles: address setup, strobe low, strobe release. `busy` is high for those three cycles. A request must be held until the cycle in which `busy` is low, and is accepted at that clock edge. The sequencer has four states:
- IDLE: waiting for a request. IDLE→SETUP when a request is accepted; otherwise it stays in IDLE.
- SETUP: the address is driven. SETUP→STROBE always.
- STROBE: one strobe is low. STROBE→RELEASE always.
- RELEASE: the strobe is high again. RELEASE→IDLE always.

Top module: `xmem_strobe_ctrl`

## Requirements
- R1: After reset, `psen_n`, `rd_n` and `wr_n` are 1, and `busy` and `rdata_vld` are 0.
- R2: An accepted fetch drives `ext_addr` from `fetch_pc`. In the STROBE cycle it drives `psen_n` low, with `rd_n` and `wr_n` high.
- R3: A move with `move_op` = 2'b10 is a constant read from program space. Its address is `move_dptr`, it strobes `psen_n`, and `move_paged` is ignored.
- R4: A move with `move_op` = 2'b00 or 2'b11 and `move_paged` = 0 is an external data read. It drives `ext_addr` from `move_dptr` and strobes only `rd_n`.
- R5: A data move with `move_paged` = 1 drives `ext_addr` = {`page_hi`, `move_rptr`}, with `page_hi` on bits 15:8.
- R6: A move with `move_op` = 2'b01 is a write. It strobes only `wr_n`, drives `ext_wdata` with the accepted `move_wdata`, and produces no `rdata_vld`.
- R7: Every access goes SETUP, STROBE, RELEASE, with `busy` high for exactly those three cycles. Each strobe is low for exactly one cycle, and never more than one strobe is low at once.
- R8: A request raised while `busy` is high starts nothing. If it is held, it is accepted on the first edge at which `busy` is low.
- R9: When `fetch_req` and `move_req` are both high at an accepting edge, the fetch is served first.
- R10: For a read, `ext_rdata` is captured at the edge that ends the STROBE cycle. It appears on `rdata` with `rdata_vld` high for exactly the RELEASE cycle.
- R11: `ext_addr` and `ext_wdata` stay constant for the whole access, even if the request inputs change after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_req | input | 1 | Opcode fetch request |
| fetch_pc | input | ADDR_W (16) | Program counter for the fetch |
| move_req | input | 1 | Data-move request |
| move_op | input | 2 | 00 data read, 01 data write, 10 constant read from program space, 11 data read |
| move_paged | input | 1 | 1 selects the paged address form |
| move_dptr | input | ADDR_W (16) | 16-bit data pointer |
| move_rptr | input | RPTR_W (8) | 8-bit register pointer for paged moves |
| page_hi | input | ADDR_W-RPTR_W (8) | Port latch supplying the page byte |
| move_wdata | input | DATA_W (8) | Write data |
| ext_rdata | input | DATA_W (8) | Data returned by the external device |
| busy | output | 1 | Access in progress; requests are held off |
| ext_addr | output | ADDR_W (16) | External address |
| psen_n | output | 1 | Program-store enable, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| ext_wdata | output | DATA_W (8) | Write data toward the external RAM |
| rdata | output | DATA_W (8) | Captured read data |
| rdata_vld | output | 1 | One-cycle valid for `rdata` |

## Verification
The bench drives a request half a cycle before an accepting edge E0. It then samples at the falling edge after each of E0, E1, E2 and E3:
- After E0 (SETUP): `busy` is high, the address is present and every strobe is still high.
- After E1 (STROBE): the expected strobe is low and the write data is present.
- After E2 (RELEASE): the strobes are high again, and `rdata`/`rdata_vld` are due.
- After E3 (IDLE): `busy` has dropped.

Each check samples only at the one falling edge where its result is due. The request inputs are scrambled after acceptance to show that they no longer matter. The priority case keeps the losing move request raised and expects it to start one edge after `busy` falls.

// File: rtl/xmem_pkg.sv
package xmem_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SETUP   = 2'd1,
        ST_STROBE  = 2'd2,
        ST_RELEASE = 2'd3
    } seq_state_t;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_CODE  = 2'd1,
        ACC_XRD   = 2'd2,
        ACC_XWR   = 2'd3
    } acc_kind_t;

    localparam logic [1:0] MOP_XRD  = 2'b00;
    localparam logic [1:0] MOP_XWR  = 2'b01;
    localparam logic [1:0] MOP_CRD  = 2'b10;
    localparam logic [1:0] MOP_XRD2 = 2'b11;

endpackage

// File: rtl/xmem_req_select.sv
module xmem_req_select
    import xmem_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int RPTR_W = 8,
    localparam int PAGE_W = ADDR_W - RPTR_W
) (
    input  logic              fetch_req,
    input  logic [ADDR_W-1:0] fetch_pc,
    input  logic              move_req,
    input  logic [1:0]        move_op,
    input  logic              move_paged,
    input  logic [ADDR_W-1:0] move_dptr,
    input  logic [RPTR_W-1:0] move_rptr,
    input  logic [PAGE_W-1:0] page_hi,
    input  logic [DATA_W-1:0] move_wdata,
    output logic              sel_valid,
    output acc_kind_t         sel_kind,
    output logic [ADDR_W-1:0] sel_addr,
    output logic [DATA_W-1:0] sel_wdata
);

    logic [ADDR_W-1:0] paged_addr;
    acc_kind_t         move_kind;

    generate
        if (PAGE_W > 0) begin : g_paged
            assign paged_addr = {page_hi, move_rptr};
        end else begin : g_flat
            assign paged_addr = move_rptr[ADDR_W-1:0];
        end
    endgenerate

    always_comb begin
        case (move_op)
            MOP_XWR:  move_kind = ACC_XWR;
            MOP_CRD:  move_kind = ACC_CODE;
            default:  move_kind = ACC_XRD;
        endcase
    end

    // Fetch outranks a data move in the same cycle (R9).
    always_comb begin
        sel_valid = fetch_req | move_req;
        sel_wdata = move_wdata;
        if (fetch_req) begin
            sel_kind = ACC_FETCH;
            sel_addr = fetch_pc;
        end else begin
            sel_kind = move_kind;
            if (move_paged && move_kind != ACC_CODE) begin
                sel_addr = paged_addr;
            end else begin
                sel_addr = move_dptr;
            end
        end
    end

endmodule

// File: rtl/xmem_seq.sv
module xmem_seq
    import xmem_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  acc_kind_t         req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] ext_rdata,
    output logic              busy,
    output logic [ADDR_W-1:0] ext_addr,
    output logic              psen_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic [DATA_W-1:0] ext_wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_vld
);

    seq_state_t        state_q, state_d;
    acc_kind_t         kind_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              vld_q;
    logic              is_read;

    assign is_read = (kind_q != ACC_XWR);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (req_valid) state_d = ST_SETUP;
            ST_SETUP:   state_d = ST_STROBE;
            ST_STROBE:  state_d = ST_RELEASE;
            ST_RELEASE: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            kind_q  <= ACC_FETCH;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            vld_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && req_valid) begin
                kind_q  <= req_kind;
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (state_q == ST_STROBE && is_read) begin
                rdata_q <= ext_rdata;
            end
            vld_q <= (state_q == ST_STROBE) && is_read;
        end
    end

    always_comb begin
        busy      = (state_q != ST_IDLE);
        ext_addr  = addr_q;
        ext_wdata = wdata_q;
        rdata     = rdata_q;
        rdata_vld = vld_q;
        psen_n    = 1'b1;
        rd_n      = 1'b1;
        wr_n      = 1'b1;
        if (state_q == ST_STROBE) begin
            unique case (kind_q)
                ACC_FETCH, ACC_CODE: psen_n = 1'b0;
                ACC_XRD:             rd_n   = 1'b0;
                ACC_XWR:             wr_n   = 1'b0;
            endcase
        end
    end

    // R7: strobes are mutually exclusive
    a_r7_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({~psen_n, ~rd_n, ~wr_n}) <= 1);

    // R7: a strobe is low for one cycle only
    a_r7_strobe_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (!psen_n || !rd_n || !wr_n) |=> (psen_n && rd_n && wr_n));

    // R7: busy lasts exactly three cycles
    a_r7_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> busy ##1 busy ##1 !busy);

    // R11: address and write data held during an access
    a_r11_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(ext_addr) && $stable(ext_wdata)));

    // R10: valid follows a read strobe and lasts one cycle
    a_r10_vld_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_vld |-> $past(!rd_n || !psen_n));

    a_r10_vld_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_vld |=> !rdata_vld);

endmodule

// File: rtl/xmem_strobe_ctrl.sv
module xmem_strobe_ctrl
    import xmem_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int RPTR_W = 8,
    localparam int PAGE_W = ADDR_W - RPTR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_req,
    input  logic [ADDR_W-1:0] fetch_pc,
    input  logic              move_req,
    input  logic [1:0]        move_op,
    input  logic              move_paged,
    input  logic [ADDR_W-1:0] move_dptr,
    input  logic [RPTR_W-1:0] move_rptr,
    input  logic [PAGE_W-1:0] page_hi,
    input  logic [DATA_W-1:0] move_wdata,
    input  logic [DATA_W-1:0] ext_rdata,
    output logic              busy,
    output logic [ADDR_W-1:0] ext_addr,
    output logic              psen_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic [DATA_W-1:0] ext_wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_vld
);

    logic              sel_valid;
    acc_kind_t         sel_kind;
    logic [ADDR_W-1:0] sel_addr;
    logic [DATA_W-1:0] sel_wdata;

    xmem_req_select #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .RPTR_W (RPTR_W)
    ) u_select (
        .fetch_req  (fetch_req),
        .fetch_pc   (fetch_pc),
        .move_req   (move_req),
        .move_op    (move_op),
        .move_paged (move_paged),
        .move_dptr  (move_dptr),
        .move_rptr  (move_rptr),
        .page_hi    (page_hi),
        .move_wdata (move_wdata),
        .sel_valid  (sel_valid),
        .sel_kind   (sel_kind),
        .sel_addr   (sel_addr),
        .sel_wdata  (sel_wdata)
    );

    xmem_seq #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (sel_valid),
        .req_kind  (sel_kind),
        .req_addr  (sel_addr),
        .req_wdata (sel_wdata),
        .ext_rdata (ext_rdata),
        .busy      (busy),
        .ext_addr  (ext_addr),
        .psen_n    (psen_n),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .ext_wdata (ext_wdata),
        .rdata     (rdata),
        .rdata_vld (rdata_vld)
    );

    // R9: an accepted fetch strobes program-store enable two cycles later
    a_r9_fetch_first: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && fetch_req) |=> ##1 !psen_n);

    // R8: requests raised while busy start no new setup
    a_r8_held_off: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && $past(busy, 2)) |=> !busy);

    // R1/R7: no strobe while idle
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (psen_n && rd_n && wr_n));

endmodule

// File: tb/xmem_strobe_ctrl_tb_top.sv
`timescale 1ns/1ps
module xmem_strobe_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_req = 1'b0;
    logic [15:0] fetch_pc = '0;
    logic        move_req = 1'b0;
    logic [1:0]  move_op = '0;
    logic        move_paged = 1'b0;
    logic [15:0] move_dptr = '0;
    logic [7:0]  move_rptr = '0;
    logic [7:0]  page_hi = '0;
    logic [7:0]  move_wdata = '0;
    logic [7:0]  ext_rdata;
    logic        busy, psen_n, rd_n, wr_n, rdata_vld;
    logic [15:0] ext_addr;
    logic [7:0]  ext_wdata, rdata;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    // external device model: program memory and data RAM answer differently
    function automatic logic [7:0] code_byte(input logic [15:0] a);
        return a[7:0] ^ 8'h5A;
    endfunction
    function automatic logic [7:0] ram_byte(input logic [15:0] a);
        return a[15:8] + a[7:0];
    endfunction
    assign ext_rdata = !psen_n ? code_byte(ext_addr) :
                       (!rd_n ? ram_byte(ext_addr) : 8'h00);

    xmem_strobe_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .fetch_req(fetch_req), .fetch_pc(fetch_pc),
        .move_req(move_req), .move_op(move_op), .move_paged(move_paged),
        .move_dptr(move_dptr), .move_rptr(move_rptr), .page_hi(page_hi),
        .move_wdata(move_wdata), .ext_rdata(ext_rdata),
        .busy(busy), .ext_addr(ext_addr), .psen_n(psen_n), .rd_n(rd_n),
        .wr_n(wr_n), .ext_wdata(ext_wdata), .rdata(rdata), .rdata_vld(rdata_vld)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    typedef struct packed {
        logic        fetch;
        logic [1:0]  op;
        logic        paged;
        logic [15:0] ptr16;
        logic [7:0]  rptr;
        logic [7:0]  page;
        logic [7:0]  wd;
        logic [15:0] exp_addr;
        logic [1:0]  exp_str;   // 0 psen, 1 rd, 2 wr
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 2'b00, 1'b0, 16'h1234, 8'h00, 8'h00, 8'h00, 16'h1234, 2'd0},
        '{1'b1, 2'b00, 1'b0, 16'hFFFF, 8'h00, 8'h00, 8'h00, 16'hFFFF, 2'd0},
        '{1'b0, 2'b00, 1'b0, 16'h8000, 8'h11, 8'h22, 8'h00, 16'h8000, 2'd1},
        '{1'b0, 2'b01, 1'b0, 16'h0000, 8'h33, 8'h44, 8'hA5, 16'h0000, 2'd2},
        '{1'b0, 2'b00, 1'b1, 16'h7777, 8'h80, 8'h3C, 8'h00, 16'h3C80, 2'd1},
        '{1'b0, 2'b01, 1'b1, 16'h6666, 8'hFF, 8'h00, 8'h5A, 16'h00FF, 2'd2},
        '{1'b0, 2'b10, 1'b1, 16'h0100, 8'h22, 8'h11, 8'h00, 16'h0100, 2'd0},
        '{1'b0, 2'b11, 1'b0, 16'hABCD, 8'h01, 8'h02, 8'h00, 16'hABCD, 2'd1}
    };

    function automatic string tag_of(input vec_t v);
        if (v.fetch)           return "R2";
        if (v.op == 2'b10)     return "R3";
        if (v.op == 2'b01)     return "R6";
        if (v.paged)           return "R5";
        return "R4";
    endfunction

    task automatic run_vec(input vec_t v);
        string t;
        logic [7:0] exp_rd;
        t = tag_of(v);
        exp_rd = (v.exp_str == 2'd0) ? code_byte(v.exp_addr) : ram_byte(v.exp_addr);
        @(negedge clk);
        fetch_req  = v.fetch;
        fetch_pc   = v.ptr16;
        move_req   = !v.fetch;
        move_op    = v.op;
        move_paged = v.paged;
        move_dptr  = v.ptr16;
        move_rptr  = v.rptr;
        page_hi    = v.page;
        move_wdata = v.wd;
        @(negedge clk);             // SETUP
        fetch_req = 1'b0; move_req = 1'b0;
        fetch_pc = ~fetch_pc; move_dptr = ~move_dptr; move_rptr = ~move_rptr;
        page_hi = ~page_hi; move_wdata = ~move_wdata;
        chk(t, "setup address", ext_addr, v.exp_addr);
        chk("R7", "setup busy", busy, 1'b1);
        chk("R7", "setup strobes idle", {psen_n, rd_n, wr_n}, 3'b111);
        @(negedge clk);             // STROBE
        chk(t, "strobe pattern", {psen_n, rd_n, wr_n},
            (v.exp_str == 2'd0) ? 3'b011 : ((v.exp_str == 2'd1) ? 3'b101 : 3'b110));
        chk("R11", "address held", ext_addr, v.exp_addr);
        if (v.exp_str == 2'd2) chk("R6", "write data", ext_wdata, v.wd);
        @(negedge clk);             // RELEASE
        chk("R7", "release strobes", {psen_n, rd_n, wr_n}, 3'b111);
        chk("R7", "release busy", busy, 1'b1);
        chk("R10", "valid pulse", rdata_vld, (v.exp_str != 2'd2));
        if (v.exp_str != 2'd2) chk("R10", "read data", rdata, exp_rd);
        @(negedge clk);             // IDLE
        chk("R7", "idle busy", busy, 1'b0);
        chk("R10", "valid dropped", rdata_vld, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "reset strobes", {psen_n, rd_n, wr_n}, 3'b111);
        chk("R1", "reset busy", busy, 1'b0);
        chk("R1", "reset valid", rdata_vld, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "idle after reset", {busy, psen_n, rd_n, wr_n}, 4'b0111);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R9 and R8: both requests together, move held through the fetch
        @(negedge clk);
        fetch_req = 1'b1; fetch_pc = 16'h0042;
        move_req = 1'b1; move_op = 2'b00; move_paged = 1'b0; move_dptr = 16'h9000;
        @(negedge clk);
        fetch_req = 1'b0;
        chk("R9", "fetch served first addr", ext_addr, 16'h0042);
        @(negedge clk);
        chk("R9", "fetch strobe", {psen_n, rd_n, wr_n}, 3'b011);
        chk("R8", "held move not started", ext_addr, 16'h0042);
        @(negedge clk);
        chk("R8", "busy through release", busy, 1'b1);
        @(negedge clk);
        chk("R8", "idle gap before held move", busy, 1'b0);
        @(negedge clk);
        move_req = 1'b0;
        chk("R8", "held move accepted", {busy, ext_addr}, {1'b1, 16'h9000});
        @(negedge clk);
        chk("R8", "held move read strobe", {psen_n, rd_n, wr_n}, 3'b101);
        @(negedge clk);
        chk("R10", "held move data", {rdata_vld, rdata}, {1'b1, ram_byte(16'h9000)});
        @(negedge clk);
        chk("R7", "back to idle", busy, 1'b0);

        // R6: write yields no valid across its whole sequence
        @(negedge clk);
        move_req = 1'b1; move_op = 2'b01; move_paged = 1'b0; move_dptr = 16'h1111;
        move_wdata = 8'hC3;
        @(negedge clk);
        move_req = 1'b0;
        @(negedge clk);
        chk("R6", "write strobe only", {psen_n, rd_n, wr_n, ext_wdata}, {3'b110, 8'hC3});
        @(negedge clk);
        chk("R6", "no valid after write", rdata_vld, 1'b0);
        @(negedge clk);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule